// File: doc/BRIEF.md
# External Interrupt Line Controller

The block gathers 28 external interrupt inputs. Each input passes through a two-flop synchronizer. A trigger setting, shared by each even/odd pair of lines, decides what sets a line's pending flag: a low level, a high level, a falling edge, a rising edge or either edge. Pending flags stay set until software clears them by writing ones. A per-line mask decides which pending flags reach the four group request outputs. Those outputs feed a parent interrupt controller, which reads back the pending and mask state to find which line fired.

Software uses a four-register interface with single-cycle strobes. There are two configuration registers, a mask register and a pending register, selected by a 2-bit address. A read returns data combinationally in the cycle `rd_en` is high. A write takes effect at the clock edge that samples `wr_en`.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0 and every trigger field is 000. The group outputs are low.
- R2: Register addresses are 0 = configuration for lines 0–15, 1 = configuration for lines 16–27, 2 = mask, 3 = pending. In a configuration register the 3-bit field for line n occupies bits ((n mod 16)/2)*4 to that position plus 2. Lines 2k and 2k+1 therefore share one field.
- R3: Trigger codes 000 (low level) and 001 (high level) set pending on every cycle the level is present. A clear therefore has no lasting effect while the level persists.
- R4: Trigger codes 010 and 011 set pending on a falling edge, 100 and 101 on a rising edge, and 110 and 111 on either edge. An edge is a change between consecutive synchronized samples. A steady input sets nothing.
- R5: Mask bit n = 1 keeps line n off its group output, while its pending flag still latches and reads back. Mask bit n = 0 lets a pending line reach its group output.
- R6: Writing 1 to bit n of the pending register clears line n's flag. Writing 0 leaves it unchanged.
- R7: When a trigger event and a write-1 clear of the same line land on the same clock edge, the flag stays set.
- R8: Output bit 0 is the OR of unmasked pending lines 0–3, bit 1 of lines 4–11, bit 2 of lines 12–19 and bit 3 of lines 20–27.
- R9: Bits 31:28 of the mask and pending registers read as zero. So do configuration bits outside the 3-bit fields, including bits 31:23 of the second configuration register. Writes to these bits have no effect.
- R10: An input change shows up in the pending flag, and in an unmasked group output, exactly three clock edges after the input changes: two synchronizer stages, then the pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 28 | Asynchronous external interrupt inputs |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high, zero otherwise |
| grp_irq | output | 4 | Grouped interrupt requests to the parent controller |

## Verification
The hardest case to reach from the ports is a trigger event and a software clear meeting on the same clock edge. Hitting it needs the write strobe placed in the exact cycle the second synchronizer stage presents a new edge. The bench drives a rising input on a falling clock edge, lets two rising edges pass, and issues the clear so that it lands on the third edge. It then checks that the flag survived. A second case that needs care is a clear against a level that is still active. The bench clears a high-level line while the input is held high, reads the flag back as still set, and clears it again after the input has dropped.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int FIELD_W       = 3;
  localparam int FIELD_STRIDE  = 4;
  localparam int LINES_PER_CFG = 16;
  localparam int NUM_GROUPS    = 4;

  localparam logic [1:0] A_CFG_LO = 2'd0;
  localparam logic [1:0] A_CFG_HI = 2'd1;
  localparam logic [1:0] A_MASK   = 2'd2;
  localparam logic [1:0] A_PEND   = 2'd3;

  // Trigger evaluation: level codes look at the present sample, edge codes
  // compare it with the sample of the previous cycle.
  function automatic logic trig_hit(input logic [FIELD_W-1:0] code,
                                    input logic cur, input logic prev);
    logic hit;
    unique casez (code)
      3'b000:  hit = ~cur;
      3'b001:  hit = cur;
      3'b01?:  hit = prev & ~cur;
      3'b10?:  hit = ~prev & cur;
      default: hit = prev ^ cur;
    endcase
    return hit;
  endfunction

  // Group bounds: 4, 8, 8, 8 lines.
  function automatic int grp_lo(input int g);
    return (g == 0) ? 0 : 4 + (g - 1) * 8;
  endfunction

  function automatic int grp_hi(input int g);
    return (g == 0) ? 3 : 11 + (g - 1) * 8;
  endfunction
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   WIDTH  = 28,
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{INIT}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extint_line.sv
module extint_line
  import extint_pkg::*;
#(
  parameter logic INIT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cur,
  input  logic [FIELD_W-1:0] code,
  input  logic               clr,
  output logic               pend
);
  logic prev;
  logic hit;

  assign hit = trig_hit(code, cur, prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= INIT;
      pend <= 1'b0;
    end else begin
      prev <= cur;
      pend <= hit | (pend & ~clr);
    end
  end

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !pend);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);
endmodule

// File: rtl/extint_group.sv
module extint_group #(
  parameter int NUM_LINES = 28,
  parameter int LO        = 0,
  parameter int HI        = 3
) (
  input  logic [NUM_LINES-1:0] pend,
  input  logic [NUM_LINES-1:0] mask,
  output logic                 req
);
  localparam int SPAN = HI - LO + 1;
  logic [SPAN-1:0] live;

  assign live = pend[HI:LO] & ~mask[HI:LO];
  assign req  = |live;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int   NUM_LINES   = 28,
  parameter int   SYNC_STAGES = 2,
  parameter int   DATA_W      = 32,
  parameter logic SYNC_INIT   = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  line_in,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [1:0]            addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_GROUPS-1:0] grp_irq
);
  localparam int NUM_PAIRS     = (NUM_LINES + 1) / 2;
  localparam int PAIRS_PER_REG = LINES_PER_CFG / 2;

  logic [FIELD_W-1:0]   cfg_q [NUM_PAIRS];
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] synced;
  logic [NUM_LINES-1:0] clr_vec;
  logic [DATA_W-1:0]    cfg_lo_rd, cfg_hi_rd;

  wire wr_cfg_lo = wr_en && (addr == A_CFG_LO);
  wire wr_cfg_hi = wr_en && (addr == A_CFG_HI);
  wire wr_mask   = wr_en && (addr == A_MASK);
  wire wr_pend   = wr_en && (addr == A_PEND);

  assign clr_vec = wr_pend ? wdata[NUM_LINES-1:0] : '0;

  // Register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAIRS; p++) cfg_q[p] <= '0;
      mask_q <= '1;
    end else begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (p < PAIRS_PER_REG) begin
          if (wr_cfg_lo) cfg_q[p] <= wdata[p*FIELD_STRIDE +: FIELD_W];
        end else begin
          if (wr_cfg_hi)
            cfg_q[p] <= wdata[(p-PAIRS_PER_REG)*FIELD_STRIDE +: FIELD_W];
        end
      end
      if (wr_mask) mask_q <= wdata[NUM_LINES-1:0];
    end
  end

  always_comb begin
    cfg_lo_rd = '0;
    cfg_hi_rd = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (p < PAIRS_PER_REG) cfg_lo_rd[p*FIELD_STRIDE +: FIELD_W] = cfg_q[p];
      else cfg_hi_rd[(p-PAIRS_PER_REG)*FIELD_STRIDE +: FIELD_W] = cfg_q[p];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        A_CFG_LO: rdata = cfg_lo_rd;
        A_CFG_HI: rdata = cfg_hi_rd;
        A_MASK:   rdata[NUM_LINES-1:0] = mask_q;
        default:  rdata[NUM_LINES-1:0] = pend;
      endcase
    end
  end

  // Input synchronizer
  extint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT))
    u_sync (.clk(clk), .rst_n(rst_n), .d(line_in), .q(synced));

  // Per-line trigger and pending flag
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    extint_line #(.INIT(SYNC_INIT)) u_line (
      .clk(clk), .rst_n(rst_n), .cur(synced[n]), .code(cfg_q[n/2]),
      .clr(clr_vec[n]), .pend(pend[n]));
  end

  // Grouped outputs
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    extint_group #(.NUM_LINES(NUM_LINES), .LO(grp_lo(g)), .HI(grp_hi(g)))
      u_grp (.pend(pend), .mask(mask_q), .req(grp_irq[g]));
  end

  assert_mask_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && (&wdata[NUM_LINES-1:0])) |=> (grp_irq == '0));
  assert_mask_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_MASK || addr == A_PEND)) |-> (rdata[DATA_W-1:NUM_LINES] == '0));
  assert_cfg_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_CFG_LO || addr == A_CFG_HI)) |-> ((rdata & 32'h8888_8888) == '0));
  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg_lo |=> (cfg_lo_rd == ($past(wdata) & 32'h7777_7777)));
endmodule

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] line_in = '1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  grp_irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  extint_ctrl i_extint_ctrl (.clk(clk), .rst_n(rst_n), .line_in(line_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .grp_irq(grp_irq));

  // {line[4:0], code[2:0], from, to, expected pending}
  localparam logic [10:0] VEC [0:10] = '{
    {5'd2,  3'b100, 1'b0, 1'b1, 1'b1},
    {5'd5,  3'b101, 1'b1, 1'b0, 1'b0},
    {5'd9,  3'b010, 1'b1, 1'b0, 1'b1},
    {5'd13, 3'b011, 1'b0, 1'b1, 1'b0},
    {5'd16, 3'b110, 1'b0, 1'b1, 1'b1},
    {5'd21, 3'b111, 1'b1, 1'b0, 1'b1},
    {5'd27, 3'b000, 1'b1, 1'b0, 1'b1},
    {5'd18, 3'b001, 1'b0, 1'b1, 1'b1},
    {5'd24, 3'b001, 1'b0, 1'b0, 1'b0},
    {5'd0,  3'b000, 1'b1, 1'b1, 1'b0},
    {5'd11, 3'b100, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic int group_of(input int line);
    if (line < 4) return 0;
    return (line - 4) / 8 + 1;
  endfunction

  function automatic logic [31:0] field_data(input int line, input logic [2:0] code);
    return 32'(code) << (((line % 16) / 2) * 4);
  endfunction

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd2, r); check("R1 mask", r, 32'h0FFF_FFFF);
    rd(2'd3, r); check("R1 pend", r, 32'h0);
    rd(2'd0, r); check("R1 cfg lo", r, 32'h0);
    rd(2'd1, r); check("R1 cfg hi", r, 32'h0);
    check("R1 grp", {28'h0, grp_irq}, 32'h0);

    // R2 / R9 layout and unused bits
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, r); check("R2 R9 cfg lo", r, 32'h7777_7777);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, r); check("R2 R9 cfg hi", r, 32'h0077_7777);
    wr(2'd2, 32'hF000_0000); rd(2'd2, r); check("R9 mask low bits", r, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, r); check("R9 mask top", r, 32'h0FFF_FFFF);
    wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    rd(2'd3, r); check("R4 steady input under both-edge", r, 32'h0);

    // Vector table: R2 R3 R4 R5 R8
    for (int v = 0; v < 11; v++) begin
      int ln; logic [2:0] code; logic from, to, ep;
      logic [31:0] exp_grp;
      ln = int'(VEC[v][10:6]); code = VEC[v][5:3];
      from = VEC[v][2]; to = VEC[v][1]; ep = VEC[v][0];
      wr(ln < 16 ? 2'd0 : 2'd1, field_data(ln, code));
      @(negedge clk) line_in[ln] = from;
      repeat (4) @(posedge clk);
      wr(2'd3, 32'h0FFF_FFFF);
      @(negedge clk) line_in[ln] = to;
      repeat (3) @(posedge clk);
      rd(2'd3, r);
      check($sformatf("R3 R4 vec%0d line%0d pend", v, ln), {31'h0, r[ln]}, {31'h0, ep});
      check($sformatf("R5 vec%0d masked grp", v), {28'h0, grp_irq}, 32'h0);
      wr(2'd2, 32'h0FFF_FFFF & ~(32'h1 << ln));
      exp_grp = ep ? (32'h1 << group_of(ln)) : 32'h0;
      check($sformatf("R8 vec%0d line%0d grp", v, ln), {28'h0, grp_irq}, exp_grp);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd0, 32'h0); wr(2'd1, 32'h0);
      @(negedge clk) line_in[ln] = 1'b1;
      repeat (4) @(posedge clk);
      wr(2'd3, 32'hFFFF_FFFF);
    end
    rd(2'd3, r); check("R6 all cleared", r, 32'h0);

    // R3 clear against active high level (line 7, pair 3)
    wr(2'd0, 32'h0000_1000);
    repeat (3) @(posedge clk);
    wr(2'd3, 32'h0000_0080);
    rd(2'd3, r); check("R3 clear while active", {31'h0, r[7]}, 32'h1);
    @(negedge clk) line_in[7:6] = 2'b00;
    repeat (4) @(posedge clk);
    wr(2'd3, 32'h0000_00C0);
    rd(2'd3, r); check("R3 clear after inactive", r, 32'h0);
    wr(2'd0, 32'h0);
    @(negedge clk) line_in[7:6] = 2'b11;
    repeat (4) @(posedge clk);
    wr(2'd3, 32'hFFFF_FFFF);

    // R10 latency (line 2 rising, pair 1 code 100)
    wr(2'd0, 32'h0000_0040);
    @(negedge clk) line_in[2] = 1'b0;
    repeat (4) @(posedge clk);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0FFF_FFFB);
    @(negedge clk) line_in[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    rd(2'd3, r); check("R10 after two edges", {31'h0, r[2]}, 32'h0);
    check("R10 grp after two edges", {28'h0, grp_irq}, 32'h0);
    rd(2'd3, r); check("R10 after three edges", {31'h0, r[2]}, 32'h1);
    check("R10 grp after three edges", {28'h0, grp_irq}, 32'h1);

    // R6 write zero leaves the flag
    wr(2'd3, 32'h0000_0000);
    rd(2'd3, r); check("R6 write zero", {31'h0, r[2]}, 32'h1);
    wr(2'd3, 32'h0000_0004);
    rd(2'd3, r); check("R6 write one clears", {31'h0, r[2]}, 32'h0);

    // R7 event and clear on the same edge (line 3 rising)
    @(negedge clk) line_in[3] = 1'b0;
    repeat (4) @(posedge clk);
    wr(2'd3, 32'hFFFF_FFFF);
    @(negedge clk) line_in[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(2'd3, 32'h0000_0008);
    rd(2'd3, r); check("R7 event wins over clear", {31'h0, r[3]}, 32'h1);
    wr(2'd3, 32'h0000_0008);
    rd(2'd3, r); check("R7 later clear", {31'h0, r[3]}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule